// File: doc/BRIEF.md
# Security-Banked Private Interrupt Register Bank

This block holds the configuration and live state of the 32 interrupts private to one processor: 16 software-generated interrupts and 16 peripheral interrupts. Software reaches it over a simple 32-bit register bus. Each bus access carries a flag that says whether it is secure. The block stores the following per interrupt:

- group bit and group-modifier bit
- enable, pending and active bits
- one-byte priority
- trigger type
- for software-generated interrupts, a two-bit field that controls non-secure access

It also holds a control register with three group-disable bits and a wake register that tracks the processor's low-power state.

When the system runs with security enabled, every non-secure access is filtered bit by bit. An interrupt whose group bit is clear is a secure interrupt. For such an interrupt, a non-secure access reads as zero and its writes are dropped. Interrupts with the group bit set are non-secure. For these, non-secure software sees a shifted view of the priority byte. A global security-disable input removes all of this filtering.

Two hardware strobes update the interrupt state directly. An acknowledge moves one interrupt from pending to active. A deactivate clears its active bit.

Top module: `irq_bank_top`

## Requirements
- R1: After reset these read as zero: the group, modifier, enable, pending, active, priority, peripheral trigger, access-control and control state. A secure read of the wake register returns 0x3, because the processor starts in low power. A secure read of offset 9 returns 0xAAAAAAAA.
- R2: Enable, pending and active each have two offsets: set at 3/5/7 and clear at 4/6/8. Each 1 written sets (set offset) or clears (clear offset) that bit, and each 0 written leaves it unchanged. Both offsets read back the current vector, with bit i holding interrupt i.
- R3: With security enabled (sec_off=0) and bus_secure=0, interrupts whose group bit is 0 read as zero and ignore writes, bit by bit. This applies to enable, pending, active, trigger configuration and priority.
- R4: A non-secure access to an interrupt with its group bit set sees the priority shifted: a read returns (p<<1)&0xFF and a write stores 0x80|(v>>1). Priority words sit at offsets 16..23, and byte lane b of word w holds interrupt 4w+b.
- R5: A non-secure access with security enabled reads zero from, and does not write, the group (offset 2), group-modifier (offset 11) and access-control (offset 12) registers. The group-modifier and access-control registers also read as zero and ignore writes whenever sec_off=1.
- R6: Offset 9 (software-generated trigger) always reads bit 2k+1 set for every visible interrupt k, meaning edge-triggered, and ignores writes. At offset 10, bit 2k+1 is the stored trigger bit of peripheral interrupt 16+k and is writable. All even bits read zero.
- R7: Offset 12 holds a two-bit field for each software-generated interrupt i, at bits [2i+1:2i], and reads back what a secure write stored.
- R8: The wake register (offset 1) reads bit0 (processor asleep) and bit1 (children asleep), both equal to the low-power state. A write loads the low-power state from bit0. With security enabled, non-secure accesses read zero and are ignored.
- R9: The control register (offset 0) holds three group-disable bits in bits [2:0]: group 0, non-secure group 1 and secure group 1. It is read and written by any access.
- R10: A read returns its data on bus_rdata with bus_rvalid high in the cycle after bus_rd. Undefined offsets (13..15 and 24..31) read as zero and ignore writes.
- R11: ack_valid clears the pending bit and sets the active bit of ack_id. deact_valid clears the active bit of deact_id. Either change is visible on the next read.
- R12: With sec_off=1, non-secure accesses see and change the group, enable, pending, active, trigger and priority state exactly as secure accesses do, with no priority shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_off | input | 1 | Security disabled when high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Access is secure |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 5 | Interrupt acknowledged |
| deact_valid | input | 1 | Deactivate strobe |
| deact_id | input | 5 | Interrupt deactivated |

## Verification
Directed sequences come first, with the group vector split into a secure half and a non-secure half. These show whether the filter works per bit or per register. Each one pairs a non-secure write with a secure read-back, and a secure write with a non-secure read, so a missing mask and a missing priority shift show up separately. A seeded random mix of reads, writes, acknowledges and deactivates then runs over every offset, including undefined ones, with both values of the bus security flag. It alternates between security enabled and security disabled, and each read is compared against a bench model of the register behaviour.

// File: rtl/irb_pkg.sv
// Shared offsets and helpers for the private interrupt register bank.
// Assumes a 32-bit data bus and word-granular offsets.
package irb_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_CTRL     = 5'd0;
    localparam logic [ADDR_W-1:0] OFS_WAKE     = 5'd1;
    localparam logic [ADDR_W-1:0] OFS_GROUP    = 5'd2;
    localparam logic [ADDR_W-1:0] OFS_EN_SET   = 5'd3;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR   = 5'd4;
    localparam logic [ADDR_W-1:0] OFS_PEND_SET = 5'd5;
    localparam logic [ADDR_W-1:0] OFS_PEND_CLR = 5'd6;
    localparam logic [ADDR_W-1:0] OFS_ACT_SET  = 5'd7;
    localparam logic [ADDR_W-1:0] OFS_ACT_CLR  = 5'd8;
    localparam logic [ADDR_W-1:0] OFS_CFG_SGI  = 5'd9;
    localparam logic [ADDR_W-1:0] OFS_CFG_PPI  = 5'd10;
    localparam logic [ADDR_W-1:0] OFS_GRPMOD   = 5'd11;
    localparam logic [ADDR_W-1:0] OFS_NSAC     = 5'd12;
    localparam logic [ADDR_W-1:0] OFS_PRIO     = 5'd16;

    // Place each bit of a 16-bit vector on the odd bit of its 2-bit lane.
    function automatic logic [31:0] odd_spread(input logic [15:0] v);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < 16; k++) r[2*k+1] = v[k];
        return r;
    endfunction

endpackage

// File: rtl/irb_secmask.sv
// Access filter: per-interrupt visibility of the current bus access.
// Assumes an interrupt with group bit set is non-secure group 1 in both
// security modes, so only the group bit decides non-secure visibility.
module irb_secmask #(
    parameter int unsigned NUM_IRQ = 32
) (
    input  logic               sec_off,
    input  logic               secure,
    input  logic [NUM_IRQ-1:0] grp,
    output logic               full,
    output logic               priv,
    output logic [NUM_IRQ-1:0] mask
);
    // Full view for secure accesses or when security is off.
    assign full = sec_off | secure;
    // Secure-only registers exist only while security is enabled.
    assign priv = ~sec_off & secure;
    // Non-secure accesses see only non-secure interrupts.
    assign mask = full ? {NUM_IRQ{1'b1}} : grp;
endmodule

// File: rtl/irb_flags.sv
// One per-interrupt state vector with set and clear bus aliases plus
// hardware set/clear strobes. Bus update first, then hardware clear,
// then hardware set (set wins on the same bit).
module irb_flags #(
    parameter int unsigned NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_we,
    input  logic               clr_we,
    input  logic [NUM_IRQ-1:0] wdata,
    input  logic [NUM_IRQ-1:0] mask,
    input  logic [NUM_IRQ-1:0] hw_set,
    input  logic [NUM_IRQ-1:0] hw_clr,
    output logic [NUM_IRQ-1:0] state
);
    logic [NUM_IRQ-1:0] state_q;
    logic [NUM_IRQ-1:0] nxt;
    logic [NUM_IRQ-1:0] hits;

    // Combine bus aliases and hardware strobes into the next state.
    always_comb begin
        hits = wdata & mask;
        nxt  = state_q;
        if (set_we) nxt = nxt | hits;
        if (clr_we) nxt = nxt & ~hits;
        nxt = (nxt & ~hw_clr) | hw_set;
    end

    // Hold the vector; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= nxt;
    end

    assign state = state_q;

    assert_set_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && hw_clr == '0) |=> ((state & $past(wdata & mask)) == $past(wdata & mask)));
    assert_clr_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && hw_set == '0) |=> ((state & $past(wdata & mask)) == '0));
    assert_hidden_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_we || clr_we) && hw_set == '0 && hw_clr == '0)
        |=> (((state ^ $past(state)) & ~$past(mask)) == '0));
    assert_hw_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((state & $past(hw_set)) == $past(hw_set)));
    assert_hw_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr != '0 && hw_set == '0 && !set_we) |=> ((state & $past(hw_clr)) == '0));
endmodule

// File: rtl/irb_prio.sv
// Byte-per-interrupt priority store with the shifted non-secure view.
// Assumes NUM_IRQ == 4 << SEL_W (four byte lanes per bus word).
module irb_prio #(
    parameter int unsigned NUM_IRQ = 32,
    parameter int unsigned SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [SEL_W-1:0]   sel,
    input  logic [31:0]        wdata,
    input  logic               full,
    input  logic [NUM_IRQ-1:0] mask,
    output logic [31:0]        rdata
);
    logic [NUM_IRQ-1:0][7:0] prio_q;

    // Store each lane of the selected word, halved for non-secure writers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else if (we) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (sel == SEL_W'(i / 4)) begin
                    if (full)         prio_q[i] <= wdata[8*(i%4) +: 8];
                    else if (mask[i]) prio_q[i] <= {1'b1, wdata[8*(i%4)+1 +: 7]};
                end
            end
        end
    end

    // Present the selected word, doubled for non-secure readers.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < 4; b++) begin
            logic [SEL_W+1:0] idx;
            idx = {sel, 2'(b)};
            if (full)           rdata[8*b +: 8] = prio_q[idx];
            else if (mask[idx]) rdata[8*b +: 8] = {prio_q[idx][6:0], 1'b0};
        end
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chk
        assert_ns_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (we && !full && mask[g] && sel == SEL_W'(g / 4)) |=> prio_q[g][7]);
        assert_ns_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (we && !full && !mask[g]) |=> $stable(prio_q[g]));
    end
endmodule

// File: rtl/irq_bank_top.sv
// Private interrupt register bank for one processor: bus decode, the
// secure-only registers, trigger configuration, control and wake state,
// and a one-cycle registered read port.
// Assumes SGI_N == PPI_N == 16 so every vector fills one 32-bit word.
module irq_bank_top
    import irb_pkg::*;
#(
    parameter int unsigned SGI_N = 16,
    parameter int unsigned PPI_N = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_off,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_secure,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic              ack_valid,
    input  logic [4:0]        ack_id,
    input  logic              deact_valid,
    input  logic [4:0]        deact_id
);
    localparam int unsigned NUM_IRQ    = SGI_N + PPI_N;
    localparam int unsigned PRIO_WORDS = NUM_IRQ / 4;
    localparam int unsigned SEL_W      = $clog2(PRIO_WORDS);

    logic [NUM_IRQ-1:0] grp_q, grpmod_q, mask;
    logic [2*SGI_N-1:0] nsac_q;
    logic [PPI_N-1:0]   cfg_q;
    logic [2:0]         ctrl_q;
    logic               lowpwr_q;
    logic               full, priv, prio_hit, known;
    logic [NUM_IRQ-1:0] en_v, pend_v, act_v, ack_vec, deact_vec;
    logic [31:0]        prio_rd, rd_mux;

    irb_secmask #(.NUM_IRQ(NUM_IRQ)) u_mask (
        .sec_off(sec_off), .secure(bus_secure), .grp(grp_q),
        .full(full), .priv(priv), .mask(mask));

    assign ack_vec   = ack_valid   ? (NUM_IRQ'(1) << ack_id)   : '0;
    assign deact_vec = deact_valid ? (NUM_IRQ'(1) << deact_id) : '0;
    assign prio_hit  = (bus_addr >= OFS_PRIO) && (int'(bus_addr) < int'(OFS_PRIO) + PRIO_WORDS);

    irb_flags #(.NUM_IRQ(NUM_IRQ)) u_en (
        .clk(clk), .rst_n(rst_n),
        .set_we(bus_wr && bus_addr == OFS_EN_SET), .clr_we(bus_wr && bus_addr == OFS_EN_CLR),
        .wdata(bus_wdata), .mask(mask), .hw_set('0), .hw_clr('0), .state(en_v));

    irb_flags #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .set_we(bus_wr && bus_addr == OFS_PEND_SET), .clr_we(bus_wr && bus_addr == OFS_PEND_CLR),
        .wdata(bus_wdata), .mask(mask), .hw_set('0), .hw_clr(ack_vec), .state(pend_v));

    irb_flags #(.NUM_IRQ(NUM_IRQ)) u_act (
        .clk(clk), .rst_n(rst_n),
        .set_we(bus_wr && bus_addr == OFS_ACT_SET), .clr_we(bus_wr && bus_addr == OFS_ACT_CLR),
        .wdata(bus_wdata), .mask(mask), .hw_set(ack_vec), .hw_clr(deact_vec), .state(act_v));

    irb_prio #(.NUM_IRQ(NUM_IRQ), .SEL_W(SEL_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .we(bus_wr && prio_hit), .sel(bus_addr[SEL_W-1:0]),
        .wdata(bus_wdata), .full(full), .mask(mask), .rdata(prio_rd));

    // Configuration, secure-only and power registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q    <= '0;
            grpmod_q <= '0;
            nsac_q   <= '0;
            cfg_q    <= '0;
            ctrl_q   <= '0;
            lowpwr_q <= 1'b1;
        end else if (bus_wr) begin
            if (bus_addr == OFS_CTRL)             ctrl_q   <= bus_wdata[2:0];
            if (bus_addr == OFS_WAKE && full)     lowpwr_q <= bus_wdata[0];
            if (bus_addr == OFS_GROUP && full)    grp_q    <= bus_wdata;
            if (bus_addr == OFS_GRPMOD && priv)   grpmod_q <= bus_wdata;
            if (bus_addr == OFS_NSAC && priv)     nsac_q   <= bus_wdata;
            if (bus_addr == OFS_CFG_PPI) begin
                for (int k = 0; k < PPI_N; k++)
                    if (mask[SGI_N+k]) cfg_q[k] <= bus_wdata[2*k+1];
            end
        end
    end

    // Select the read word for the addressed register.
    always_comb begin
        known  = 1'b1;
        rd_mux = '0;
        if (prio_hit) begin
            rd_mux = prio_rd;
        end else begin
            unique case (bus_addr)
                OFS_CTRL:                  rd_mux = {29'd0, ctrl_q};
                OFS_WAKE:                  rd_mux = full ? {30'd0, lowpwr_q, lowpwr_q} : '0;
                OFS_GROUP:                 rd_mux = full ? grp_q : '0;
                OFS_EN_SET, OFS_EN_CLR:    rd_mux = en_v & mask;
                OFS_PEND_SET, OFS_PEND_CLR: rd_mux = pend_v & mask;
                OFS_ACT_SET, OFS_ACT_CLR:  rd_mux = act_v & mask;
                OFS_CFG_SGI:               rd_mux = odd_spread(mask[SGI_N-1:0]);
                OFS_CFG_PPI:               rd_mux = odd_spread(cfg_q & mask[NUM_IRQ-1:SGI_N]);
                OFS_GRPMOD:                rd_mux = priv ? grpmod_q : '0;
                OFS_NSAC:                  rd_mux = priv ? nsac_q : '0;
                default:                   known  = 1'b0;
            endcase
        end
    end

    // Register the read response one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            bus_rdata  <= bus_rd ? rd_mux : '0;
        end
    end

    assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    assert_undef_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !known) |=> (bus_rdata == '0));
    assert_sgi_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_CFG_SGI && full) |=> (bus_rdata == 32'hAAAA_AAAA));
    assert_group_wi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !full) |=> $stable(grp_q));
    assert_secreg_wi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !priv) |=> ($stable(grpmod_q) && $stable(nsac_q)));
    assert_wake_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_WAKE && full) |=> (lowpwr_q == $past(bus_wdata[0])));
    assert_ctrl_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL) |=> (ctrl_q == $past(bus_wdata[2:0])));
endmodule

// File: tb/tb_irq_bank_top.sv
module tb_irq_bank_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_off = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_secure = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        ack_valid = 1'b0, deact_valid = 1'b0;
    logic [4:0]  ack_id = '0, deact_id = '0;

    int checks = 0;
    int fails  = 0;

    // Bench model state.
    logic [31:0] m_grp = '0, m_mod = '0, m_en = '0, m_pend = '0, m_act = '0, m_nsac = '0;
    logic [15:0] m_cfg = '0;
    logic [2:0]  m_ctrl = '0;
    logic        m_lp = 1'b1;
    logic [7:0]  m_prio [32];

    irq_bank_top dut (
        .clk(clk), .rst_n(rst_n), .sec_off(sec_off), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .ack_valid(ack_valid),
        .ack_id(ack_id), .deact_valid(deact_valid), .deact_id(deact_id));

    always #2 clk = ~clk;

    function automatic logic [31:0] vis(input logic sec);
        return (sec_off || sec) ? 32'hFFFF_FFFF : m_grp;
    endfunction

    function automatic void mw(input logic [4:0] a, input logic [31:0] d, input logic sec);
        logic        fu;
        logic        pv;
        logic [31:0] mk;
        fu = sec_off || sec;
        pv = !sec_off && sec;
        mk = vis(sec);
        case (a)
            5'd0:  m_ctrl = d[2:0];
            5'd1:  if (fu) m_lp = d[0];
            5'd2:  if (fu) m_grp = d;
            5'd3:  m_en   = m_en | (d & mk);
            5'd4:  m_en   = m_en & ~(d & mk);
            5'd5:  m_pend = m_pend | (d & mk);
            5'd6:  m_pend = m_pend & ~(d & mk);
            5'd7:  m_act  = m_act | (d & mk);
            5'd8:  m_act  = m_act & ~(d & mk);
            5'd10: for (int k = 0; k < 16; k++) if (mk[16+k]) m_cfg[k] = d[2*k+1];
            5'd11: if (pv) m_mod = d;
            5'd12: if (pv) m_nsac = d;
            default: if (a >= 5'd16 && a <= 5'd23) begin
                for (int b = 0; b < 4; b++) begin
                    int id;
                    id = (int'(a) - 16) * 4 + b;
                    if (fu) m_prio[id] = d[8*b +: 8];
                    else if (m_grp[id]) m_prio[id] = {1'b1, d[8*b+1 +: 7]};
                end
            end
        endcase
    endfunction

    function automatic logic [31:0] mr(input logic [4:0] a, input logic sec);
        logic        fu;
        logic        pv;
        logic [31:0] mk;
        logic [31:0] r;
        fu = sec_off || sec;
        pv = !sec_off && sec;
        mk = vis(sec);
        r  = '0;
        case (a)
            5'd0:       r = {29'd0, m_ctrl};
            5'd1:       r = fu ? {30'd0, m_lp, m_lp} : '0;
            5'd2:       r = fu ? m_grp : '0;
            5'd3, 5'd4: r = m_en & mk;
            5'd5, 5'd6: r = m_pend & mk;
            5'd7, 5'd8: r = m_act & mk;
            5'd9:       for (int k = 0; k < 16; k++) r[2*k+1] = mk[k];
            5'd10:      for (int k = 0; k < 16; k++) r[2*k+1] = m_cfg[k] & mk[16+k];
            5'd11:      r = pv ? m_mod : '0;
            5'd12:      r = pv ? m_nsac : '0;
            default: if (a >= 5'd16 && a <= 5'd23) begin
                for (int b = 0; b < 4; b++) begin
                    int id;
                    id = (int'(a) - 16) * 4 + b;
                    if (fu) r[8*b +: 8] = m_prio[id];
                    else if (m_grp[id]) r[8*b +: 8] = {m_prio[id][6:0], 1'b0};
                end
            end
        endcase
        return r;
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic sec);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_secure = sec;
        @(negedge clk);
        bus_wr = 1'b0;
        mw(a, d, sec);
    endtask

    task automatic rd(input logic [4:0] a, input logic sec, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_secure = sec;
        @(negedge clk);
        bus_rd = 1'b0;
        checks++;
        if (!bus_rvalid || bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%0d sec=%0d actual=%08h valid=%0b expected=%08h", req, a, sec,
                     bus_rdata, bus_rvalid, exp);
        end
    endtask

    task automatic ack(input logic [4:0] id);
        @(negedge clk);
        ack_valid = 1'b1; ack_id = id;
        @(negedge clk);
        ack_valid = 1'b0;
        m_pend[id] = 1'b0; m_act[id] = 1'b1;
    endtask

    task automatic deact(input logic [4:0] id);
        @(negedge clk);
        deact_valid = 1'b1; deact_id = id;
        @(negedge clk);
        deact_valid = 1'b0;
        m_act[id] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m_prio[i] = '0;
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'd0, 1'b1, 32'h0, "R1");
        rd(5'd1, 1'b1, 32'h3, "R1");
        rd(5'd9, 1'b1, 32'hAAAA_AAAA, "R1");
        rd(5'd3, 1'b1, 32'h0, "R1");
        rd(5'd16, 1'b1, 32'h0, "R1");
        rd(5'd12, 1'b1, 32'h0, "R1");
        // R2 set/clear aliases
        wr(5'd3, 32'h0000_00F0, 1'b1);
        rd(5'd4, 1'b1, 32'h0000_00F0, "R2");
        wr(5'd4, 32'h0000_0030, 1'b1);
        rd(5'd3, 1'b1, 32'h0000_00C0, "R2");
        // R3 per-bit non-secure filter
        wr(5'd2, 32'hFFFF_0000, 1'b1);
        wr(5'd3, 32'hFFFF_FFFF, 1'b0);
        rd(5'd3, 1'b1, 32'hFFFF_00C0, "R3");
        rd(5'd3, 1'b0, 32'hFFFF_0000, "R3");
        // R5 group register hidden from non-secure
        rd(5'd2, 1'b0, 32'h0, "R5");
        wr(5'd2, 32'h0, 1'b0);
        rd(5'd2, 1'b1, 32'hFFFF_0000, "R5");
        // R4 shifted priority view
        wr(5'd20, 32'h1122_3344, 1'b1);
        rd(5'd20, 1'b0, 32'h2244_6688, "R4");
        wr(5'd20, 32'h0204_0608, 1'b0);
        rd(5'd20, 1'b1, 32'h8182_8384, "R4");
        wr(5'd16, 32'hFFFF_FFFF, 1'b0);
        rd(5'd16, 1'b1, 32'h0, "R3");
        // R6 trigger configuration
        wr(5'd10, 32'hFFFF_FFFF, 1'b1);
        rd(5'd10, 1'b1, 32'hAAAA_AAAA, "R6");
        wr(5'd9, 32'h0, 1'b1);
        rd(5'd9, 1'b1, 32'hAAAA_AAAA, "R6");
        rd(5'd9, 1'b0, 32'h0, "R6");
        // R7 access-control fields
        wr(5'd12, 32'h0000_0006, 1'b1);
        rd(5'd12, 1'b1, 32'h0000_0006, "R7");
        rd(5'd12, 1'b0, 32'h0, "R5");
        // R8 wake register
        wr(5'd1, 32'h0, 1'b0);
        rd(5'd1, 1'b0, 32'h0, "R8");
        rd(5'd1, 1'b1, 32'h3, "R8");
        wr(5'd1, 32'h0, 1'b1);
        rd(5'd1, 1'b1, 32'h0, "R8");
        wr(5'd1, 32'h1, 1'b1);
        rd(5'd1, 1'b1, 32'h3, "R8");
        // R9 control
        wr(5'd0, 32'h0000_0005, 1'b0);
        rd(5'd0, 1'b0, 32'h5, "R9");
        // R10 undefined offsets
        wr(5'd13, 32'hFFFF_FFFF, 1'b1);
        rd(5'd13, 1'b1, 32'h0, "R10");
        rd(5'd30, 1'b1, 32'h0, "R10");
        // R11 acknowledge and deactivate
        wr(5'd5, 32'h0010_0000, 1'b1);
        ack(5'd20);
        rd(5'd5, 1'b1, 32'h0, "R11");
        rd(5'd7, 1'b1, 32'h0010_0000, "R11");
        deact(5'd20);
        rd(5'd8, 1'b1, 32'h0, "R11");
        // R12 security disabled
        sec_off = 1'b1;
        wr(5'd11, 32'hFFFF_FFFF, 1'b0);
        rd(5'd11, 1'b1, 32'h0, "R5");
        rd(5'd2, 1'b0, 32'hFFFF_0000, "R12");
        rd(5'd3, 1'b0, 32'hFFFF_00C0, "R12");
        rd(5'd20, 1'b0, 32'h8182_8384, "R12");
        sec_off = 1'b0;

        // Seeded random mix checked against the model (R2 R3 R4 R12 ...).
        for (int it = 0; it < 800; it++) begin
            int r;
            logic [4:0] a;
            logic sec;
            if (it % 200 == 100) begin
                @(negedge clk);
                sec_off = ~sec_off;
            end
            r   = int'($urandom % 27);
            a   = (r < 24) ? 5'(r) : (r == 24 ? 5'd14 : 5'd27);
            sec = 1'($urandom % 2);
            case ($urandom % 6)
                0, 1: wr(a, $urandom, sec);
                2:    ack(5'($urandom % 32));
                3:    deact(5'($urandom % 32));
                default: rd(a, sec, mr(a, sec), "R3_R12_random");
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule